// File: doc/BRIEF.md
# Pipelined-Burst Synchronous SRAM with Delayed Write

This block is a clocked on-chip memory that serves four-word bursts on a synchronous request bus. The requester offers a command (read or write) with a start word address. Upper address bits select an aligned four-word line. The two low bits pick the first word, and later beats step through the line, wrapping back to its start. A read returns its four words on consecutive cycles, starting on the fourth clock edge after the command is taken (a 4-1-1-1 profile). Reads issued every four cycles stream without gaps.

A write supplies its four data words on the write-data bus, beginning two cycles after the command. The captured line waits in a pending buffer before it reaches the array. It is committed when the next write's line is complete, or in a cycle where the bus is free and nothing is offered. A read of a line still held in the pending buffer is served from that buffer. A change of direction between two commands costs one dead bus cycle, and the ready output shows when a command is not taken.

Top module: `psb_burst_sram`

## Requirements
- R1: A burst moves four 32-bit words of one aligned line; beat k uses word index (s + k) mod 4, where s is the low two bits of the start address, and the upper address bits do not change during the burst.
- R2: For a read accepted at clock edge E, rd_valid is high with word beats 0..3 in the four cycles after edges E+4..E+7. rd_valid is low after E+3 and after E+8 when no other read is in flight.
- R3: Reads accepted four edges apart give rd_valid high for eight consecutive cycles with no gap between the bursts.
- R4: For a write accepted at edge E, wdata is sampled at edges E+2, E+3, E+4 and E+5 as beats 0..3, and each beat is stored at its wrapped word index.
- R5: After any accepted command, cmd_ready is low for the next three cycles; a following command of the same kind offered continuously is accepted exactly four edges later.
- R6: A command of the opposite kind to the previous one, offered continuously, is accepted exactly five edges after it, leaving one dead cycle.
- R7: A read of a line whose write has not yet been committed to the array returns the newly written words.
- R8: Several writes in a row, including two writes to the same line, all become readable afterwards, with the latest data winning per word; no pending line is lost when the next write's line takes its place.
- R9: After reset, rd_valid is low and cmd_ready is high; the first command of either kind is accepted with no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | ADDR_W | Start word address of the burst |
| wdata | input | 32 | Write data beat, two cycles behind its command |
| cmd_ready | output | 1 | The offered command is taken at the next edge |
| rd_valid | output | 1 | rd_data carries a read beat this cycle |
| rd_data | output | 32 | Read data beat |

## Verification
The bench records the edge at which each command is taken. Read beat k is then expected in the cycle after edge E+4+k, and write beat k is driven so that it is sampled at edge E+2+k. All samples are taken on the falling edge, where these counts are unambiguous. Acceptance spacing is measured as the difference of recorded edges: four for the same kind, five across a direction change. Quiet cycles are checked right before the first read beat and right after the last one.

// File: rtl/psb_pkg.sv
package psb_pkg;
    localparam int unsigned PSB_DW    = 32;
    localparam int unsigned PSB_BEATS = 4;
    localparam int unsigned PSB_BW    = $clog2(PSB_BEATS);

    typedef logic [PSB_DW-1:0]             word_t;
    typedef word_t [PSB_BEATS-1:0]         line_t;
    typedef logic [PSB_BW-1:0]             beat_t;
endpackage

// File: rtl/psb_lag_pipe.sv
module psb_lag_pipe #(
    parameter int unsigned DEPTH = 1,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic         vld_d;
        logic [W-1:0] data_d;
        if (g == 0) begin : g_head
            always_comb begin
                vld_d  = in_vld;
                data_d = in_data;
            end
        end else begin : g_body
            always_comb begin
                vld_d  = vld_q[g-1];
                data_d = data_q[g-1];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                data_q[g] <= '0;
            end else begin
                vld_q[g]  <= vld_d;
                data_q[g] <= data_d;
            end
        end
    end

    assign out_vld  = vld_q[DEPTH-1];
    assign out_data = data_q[DEPTH-1];
endmodule

// File: rtl/psb_bus_ctrl.sv
module psb_bus_ctrl #(
    parameter int unsigned BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_write,
    output logic cmd_ready,
    output logic accept,
    output logic slot_free
);
    localparam int unsigned CW = $clog2(BEATS);

    typedef struct packed {
        logic [CW-1:0] busy;
        logic          last_wr;
        logic          have_last;
        logic          idle;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        slot_free = (c_q.busy == '0);
        cmd_ready = slot_free &&
                    (!c_q.have_last || (cmd_write == c_q.last_wr) || c_q.idle);
        accept    = cmd_valid && cmd_ready;
        c_d       = c_q;
        if (accept) begin
            c_d.busy      = CW'(BEATS - 1);
            c_d.last_wr   = cmd_write;
            c_d.have_last = 1'b1;
            c_d.idle      = 1'b0;
        end else if (!slot_free) begin
            c_d.busy = c_q.busy - 1'b1;
            c_d.idle = 1'b0;
        end else begin
            c_d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/psb_array.sv
module psb_array #(
    parameter int unsigned LINE_W = 4
) (
    input  logic                clk,
    input  logic                we,
    input  logic [LINE_W-1:0]   waddr,
    input  psb_pkg::line_t      wline,
    input  logic [LINE_W-1:0]   raddr,
    output psb_pkg::line_t      rline
);
    localparam int unsigned LINES = 2 ** LINE_W;

    psb_pkg::line_t mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wline;
    end

    assign rline = mem[raddr];
endmodule

// File: rtl/psb_burst_sram.sv
module psb_burst_sram #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned RD_LAT = 4,
    parameter int unsigned WR_LAG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic                      cmd_write,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic [psb_pkg::PSB_DW-1:0] wdata,
    output logic                      cmd_ready,
    output logic                      rd_valid,
    output logic [psb_pkg::PSB_DW-1:0] rd_data
);
    import psb_pkg::*;

    localparam int unsigned LINE_W = ADDR_W - PSB_BW;
    localparam beat_t       LAST   = beat_t'(PSB_BEATS - 1);

    typedef struct packed {
        logic              rd_act;
        beat_t             rd_beat;
        logic [LINE_W-1:0] rd_line;
        beat_t             rd_low;
        logic              wr_act;
        beat_t             wr_beat;
        logic [LINE_W-1:0] wr_line;
        beat_t             wr_low;
        line_t             wr_cap;
        logic              pend_vld;
        logic [LINE_W-1:0] pend_line;
        line_t             pend_data;
        logic              out_vld;
        word_t             out_data;
    } state_t;

    state_t s_q, s_d;

    logic              accept, slot_free;
    logic              rp_vld, wp_vld;
    logic [ADDR_W-1:0] rp_addr, wp_addr;
    line_t             arr_rline;
    logic              commit;
    beat_t             rd_idx, wr_idx;
    line_t             cap;
    logic              fwd;

    psb_bus_ctrl #(.BEATS(PSB_BEATS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .slot_free (slot_free)
    );

    psb_lag_pipe #(.DEPTH(RD_LAT - 1), .W(ADDR_W)) u_rd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (accept && !cmd_write),
        .in_data  (cmd_addr),
        .out_vld  (rp_vld),
        .out_data (rp_addr)
    );

    psb_lag_pipe #(.DEPTH(WR_LAG - 1), .W(ADDR_W)) u_wr_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (accept && cmd_write),
        .in_data  (cmd_addr),
        .out_vld  (wp_vld),
        .out_data (wp_addr)
    );

    psb_array #(.LINE_W(LINE_W)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (s_q.pend_line),
        .wline (s_q.pend_data),
        .raddr (s_q.rd_line),
        .rline (arr_rline)
    );

    always_comb begin
        s_d         = s_q;
        s_d.out_vld = 1'b0;
        commit      = 1'b0;
        rd_idx      = s_q.rd_low + s_q.rd_beat;
        wr_idx      = s_q.wr_low + s_q.wr_beat;
        fwd         = s_q.pend_vld && (s_q.pend_line == s_q.rd_line);
        cap         = s_q.wr_cap;
        cap[wr_idx] = wdata;

        // read beat engine: one word per cycle while active
        if (s_q.rd_act) begin
            s_d.out_vld  = 1'b1;
            s_d.out_data = fwd ? s_q.pend_data[rd_idx] : arr_rline[rd_idx];
            s_d.rd_beat  = s_q.rd_beat + 1'b1;
            if (s_q.rd_beat == LAST) s_d.rd_act = 1'b0;
        end
        if (rp_vld) begin
            s_d.rd_act  = 1'b1;
            s_d.rd_beat = '0;
            s_d.rd_line = rp_addr[ADDR_W-1:PSB_BW];
            s_d.rd_low  = rp_addr[PSB_BW-1:0];
        end

        // write capture engine and pending line handling
        if (s_q.wr_act) begin
            s_d.wr_cap  = cap;
            s_d.wr_beat = s_q.wr_beat + 1'b1;
            if (s_q.wr_beat == LAST) begin
                s_d.wr_act    = 1'b0;
                commit        = s_q.pend_vld;
                s_d.pend_vld  = 1'b1;
                s_d.pend_line = s_q.wr_line;
                s_d.pend_data = cap;
            end
        end
        if (!(s_q.wr_act && s_q.wr_beat == LAST) &&
            s_q.pend_vld && slot_free && !cmd_valid) begin
            commit       = 1'b1;
            s_d.pend_vld = 1'b0;
        end
        if (wp_vld) begin
            s_d.wr_act  = 1'b1;
            s_d.wr_beat = '0;
            s_d.wr_line = wp_addr[ADDR_W-1:PSB_BW];
            s_d.wr_low  = wp_addr[PSB_BW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.out_vld;
    assign rd_data  = s_q.out_data;
endmodule

// File: rtl/psb_checks.sv
module psb_checks (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_write,
    input logic cmd_ready,
    input logic rd_valid
);
    logic       acc;
    logic [2:0] gap_q;
    logic       last_wr_q, have_q;
    logic [3:0] owed_q;

    assign acc = cmd_valid && cmd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= 3'd7;
            last_wr_q <= 1'b0;
            have_q    <= 1'b0;
            owed_q    <= '0;
        end else begin
            if (acc) begin
                gap_q     <= 3'd1;
                last_wr_q <= cmd_write;
                have_q    <= 1'b1;
            end else if (gap_q != 3'd7) begin
                gap_q <= gap_q + 3'd1;
            end
            owed_q <= owed_q + ((acc && !cmd_write) ? 4'd4 : 4'd0)
                             - (rd_valid ? 4'd1 : 4'd0);
        end
    end

    // R5: no command is taken within a burst slot
    a_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> gap_q >= 3'd4);

    // R6: a change of direction leaves one dead cycle
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && have_q && (cmd_write != last_wr_q)) |-> gap_q >= 3'd5);

    // R2: every read beat is owed by an accepted read
    a_r2_beat_owed: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> owed_q != 4'd0);

    // R3: at most two read bursts are outstanding
    a_r3_owed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= 4'd8);

    // R9: output quiet when reset is released
    a_r9_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !rd_valid);
endmodule

bind psb_burst_sram psb_checks u_psb_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_ready (cmd_ready),
    .rd_valid  (rd_valid)
);

// File: tb/psb_burst_sram_test.sv
module psb_burst_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [31:0]   wdata = '0;
    logic          cmd_ready, rd_valid;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;
    int ecount = 0;
    logic [31:0] model [64];

    psb_burst_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .wdata(wdata), .cmd_ready(cmd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_edge(input int e);
        while (ecount < e) @(negedge clk);
    endtask

    // offer a command from a falling edge, return the accepting edge
    task automatic issue(input bit wr, input logic [AW-1:0] a, output int acc);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        while (!cmd_ready) @(negedge clk);
        acc = ecount + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic [31:0] seed, output int acc);
        logic [31:0] w [4];
        for (int b = 0; b < 4; b++) begin
            w[b] = seed + 32'(b);
            model[{a[AW-1:2], 2'(a[1:0] + 2'(b))}] = w[b];
        end
        issue(1'b1, a, acc);
        fork
            begin
                for (int b = 0; b < 4; b++) begin
                    wait_edge(acc + 1 + b);
                    wdata = w[b];
                end
            end
        join_none
    endtask

    task automatic rd_burst(input logic [AW-1:0] a, input string tag, output int acc);
        logic [31:0] e [4];
        for (int b = 0; b < 4; b++)
            e[b] = model[{a[AW-1:2], 2'(a[1:0] + 2'(b))}];
        issue(1'b0, a, acc);
        fork
            begin
                for (int b = 0; b < 4; b++) begin
                    wait_edge(acc + 4 + b);
                    chk(rd_valid === 1'b1, {tag, " rd_valid beat"}, 32'(rd_valid), 32'd1);
                    chk(rd_data === e[b], {tag, " rd_data beat"}, rd_data, e[b]);
                end
            end
        join_none
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid === 1'b0, "R9 rd_valid after reset", 32'(rd_valid), 32'd0);
        chk(cmd_ready === 1'b1, "R9 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    endtask

    // write then read of the same line, read offered at once
    task automatic t_forward();
        int a0, a1;
        wr_burst(6'h00, 32'h1000, a0);
        chk(a0 == ecount, "R9 first command without dead cycle", 32'(a0), 32'(ecount));
        rd_burst(6'h00, "R7 R4 R1", a1);
        chk(a1 - a0 == 5, "R6 write to read spacing", 32'(a1 - a0), 32'd5);
        settle();
    endtask

    task automatic t_latency();
        int a0;
        rd_burst(6'h01, "R2 R1 wrap", a0);
        wait_edge(a0 + 3);
        chk(rd_valid === 1'b0, "R2 quiet before first beat", 32'(rd_valid), 32'd0);
        wait_edge(a0 + 8);
        chk(rd_valid === 1'b0, "R2 quiet after last beat", 32'(rd_valid), 32'd0);
        settle();
    endtask

    task automatic t_stream();
        int a0, a1, a2, r0, r1, r2;
        wr_burst(6'h13, 32'h2000, a0);
        wr_burst(6'h20, 32'h3000, a1);
        wr_burst(6'h2A, 32'h4000, a2);
        chk(a1 - a0 == 4, "R5 write spacing", 32'(a1 - a0), 32'd4);
        chk(a2 - a1 == 4, "R5 write spacing", 32'(a2 - a1), 32'd4);
        settle();
        rd_burst(6'h13, "R8 R3", r0);
        rd_burst(6'h20, "R8 R3", r1);
        rd_burst(6'h2A, "R8 R3", r2);
        chk(r1 - r0 == 4, "R3 read spacing", 32'(r1 - r0), 32'd4);
        chk(r2 - r1 == 4, "R3 read spacing", 32'(r2 - r1), 32'd4);
        settle();
    endtask

    task automatic t_overwrite();
        int a0, a1, r0;
        wr_burst(6'h30, 32'h5000, a0);
        wr_burst(6'h32, 32'h6000, a1);
        settle();
        rd_burst(6'h30, "R8 same line", r0);
        settle();
    endtask

    task automatic t_rd_to_wr();
        int r0, a0, r1;
        rd_burst(6'h13, "R2 before turn", r0);
        wr_burst(6'h3F, 32'h7000, a0);
        chk(a0 - r0 == 5, "R6 read to write spacing", 32'(a0 - r0), 32'd5);
        rd_burst(6'h3C, "R7 R4 wrap", r1);
        chk(r1 - a0 == 5, "R6 write to read spacing", 32'(r1 - a0), 32'd5);
        settle();
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        for (int i = 0; i < 64; i++) model[i] = 32'hDEAD0000 + 32'(i);
        @(negedge clk);
        t_reset();
        t_forward();
        t_latency();
        t_stream();
        t_overwrite();
        t_rd_to_wr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule